// File: doc/BRIEF.md
# Subtract Instruction Execution Unit

This block carries out the two 8-bit subtract operations of a small accumulator-style controller core. Both of them subtract the working register W. In the immediate form, the minuend is an 8-bit constant carried in the instruction word, and the difference always lands in W. In the register form, the minuend is a byte in a banked data file. A destination bit then sends the difference either to W or back to that same byte. An addressing bit picks one of two sources for the upper address bits: the bank register, or a fixed split map that reaches both low bank 0 and the top special-function bank.

Each instruction takes one cycle of four clock phases, counted by a free-running phase counter. In the first phase the unit latches the instruction word. In the second it resolves the address and reads the operand. In the third it computes the difference and the five status flags. In the fourth it commits them. Any instruction word that is not one of the two subtracts runs through the same four phases and leaves all state untouched. A load strobe writes the 4-bit bank register. A combinational read port exposes any byte of the data file. Only a few low banks and the top bank hold storage; any other bank reads as zero and drops writes.

Top module: `subx_unit`

## Requirements
- R1: Instruction word 0x08kk (bits 15..8 = 0000_1000) replaces W with (k − W) mod 256.
- R2: Instruction word 0101_11da_ffff_ffff computes (f − W) mod 256 from the addressed byte. With d (bit 9) = 1 it writes the difference back to that byte and leaves W unchanged.
- R3: With d = 0, the register form writes the difference to W and leaves the addressed byte unchanged.
- R4: With a (bit 8) = 0, the 12-bit address is {0x0, f} for f below 0x80 and {0xF, f} for f at or above 0x80. The bank register has no effect on it.
- R5: With a = 1, the address is {bank register, f}. Banks 0 to DATA_BANKS−1 and bank 0xF hold storage. Every other bank reads 0 and ignores writes.
- R6: status bit 0 (C) is 1 when the minuend is greater than or equal to W as unsigned values, and 0 on a borrow.
- R7: status bit 1 (DC) is 1 when the minuend's low nibble is greater than or equal to W's low nibble.
- R8: status bit 2 (Z) is 1 exactly when the 8-bit difference is zero, and status bit 4 (N) equals bit 7 of the difference.
- R9: status bit 3 (OV) is 1 when the signed difference of the two operands falls outside −128..127.
- R10: Any other instruction word changes neither W, nor the status flags, nor any data byte.
- R11: phase steps 0,1,2,3,0 on every clock. The instruction word is sampled at the edge that ends phase 0. W, status and data bytes change only at the edge that ends phase 3.
- R12: A synchronous reset sets phase to 0 and clears W, the bank register, the status flags and all data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word, sampled at the end of phase 0 |
| bank_load | input | 1 | Load strobe for the bank register |
| bank_din | input | 4 | New bank register value |
| rd_addr | input | 12 | Data file read address |
| phase | output | 2 | Current phase, 0 to 3 |
| w_out | output | 8 | Working register W |
| status_out | output | 5 | Flags {N, OV, Z, DC, C}, bit 4 down to bit 0 |
| rd_data | output | 8 | Data byte at rd_addr |

## Verification
The hardest state to reach from the ports is a data byte that holds a chosen value. Nothing writes the file except the subtract itself, and the file starts at zero after reset. The bench first uses the immediate form to place the negation of the target value in W. It then issues a register-form write-back to the zero byte, which leaves exactly the target value in it. This sets up operand pairs that cross the nibble, sign and borrow boundaries, and it also places bytes in the top bank and in unimplemented banks so the two addressing modes can be told apart.

// File: rtl/subx_pkg.sv
package subx_pkg;
  localparam int DATA_W = 8;
  localparam int BANK_W = 4;
  localparam int ADDR_W = BANK_W + DATA_W;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;

  typedef enum logic [1:0] {OP_NONE, OP_LIT, OP_REG} op_e;

  function automatic logic [DATA_W-1:0] sub_result(input logic [DATA_W-1:0] m,
                                                   input logic [DATA_W-1:0] w);
    return m - w;
  endfunction

  function automatic flags_t sub_flags(input logic [DATA_W-1:0] m,
                                       input logic [DATA_W-1:0] w);
    flags_t f;
    logic [DATA_W:0] full;
    logic [4:0] low;
    full = {1'b0, m} - {1'b0, w};
    low  = {1'b0, m[3:0]} - {1'b0, w[3:0]};
    f.c  = ~full[DATA_W];
    f.dc = ~low[4];
    f.z  = (full[DATA_W-1:0] == '0);
    f.n  = full[DATA_W-1];
    f.ov = (m[DATA_W-1] != w[DATA_W-1]) && (full[DATA_W-1] != m[DATA_W-1]);
    return f;
  endfunction

  function automatic logic [ADDR_W-1:0] eff_address(input logic [DATA_W-1:0] f,
                                                    input logic a,
                                                    input logic [BANK_W-1:0] bank);
    if (a) return {bank, f};
    if (f[DATA_W-1]) return {{BANK_W{1'b1}}, f};
    return {{BANK_W{1'b0}}, f};
  endfunction
endpackage

// File: rtl/subx_decode.sv
module subx_decode
  import subx_pkg::*;
(
  input  logic [15:0]       ir,
  output op_e               op,
  output logic              dest_f,
  output logic              acc_sel,
  output logic [DATA_W-1:0] field
);
  always_comb begin
    op = OP_NONE;
    if (ir[15:8] == 8'b0000_1000) op = OP_LIT;
    else if (ir[15:10] == 6'b0101_11) op = OP_REG;
  end
  assign dest_f  = ir[9];
  assign acc_sel = ir[8];
  assign field   = ir[7:0];
endmodule

// File: rtl/subx_regfile.sv
module subx_regfile
  import subx_pkg::*;
#(
  parameter int DATA_BANKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data
);
  localparam int NSLOT  = DATA_BANKS + 1;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int DEPTH  = 1 << DATA_W;

  function automatic logic [SLOT_W:0] slot_of(input logic [BANK_W-1:0] bank);
    if (bank == {BANK_W{1'b1}}) return {1'b1, SLOT_W'(NSLOT - 1)};
    if (int'(bank) < DATA_BANKS) return {1'b1, SLOT_W'(bank)};
    return '0;
  endfunction

  logic [SLOT_W:0] wr_slot, rd0_slot, rd1_slot;
  logic [DATA_W-1:0] rd0_vals [NSLOT];
  logic [DATA_W-1:0] rd1_vals [NSLOT];

  assign wr_slot  = slot_of(wr_addr[ADDR_W-1:DATA_W]);
  assign rd0_slot = slot_of(rd0_addr[ADDR_W-1:DATA_W]);
  assign rd1_slot = slot_of(rd1_addr[ADDR_W-1:DATA_W]);

  for (genvar g = 0; g < NSLOT; g++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en && wr_slot[SLOT_W] && wr_slot[SLOT_W-1:0] == SLOT_W'(g)) begin
        mem[wr_addr[DATA_W-1:0]] <= wr_data;
      end
    end
    assign rd0_vals[g] = mem[rd0_addr[DATA_W-1:0]];
    assign rd1_vals[g] = mem[rd1_addr[DATA_W-1:0]];
  end

  assign rd0_data = rd0_slot[SLOT_W] ? rd0_vals[rd0_slot[SLOT_W-1:0]] : '0;
  assign rd1_data = rd1_slot[SLOT_W] ? rd1_vals[rd1_slot[SLOT_W-1:0]] : '0;
endmodule

// File: rtl/subx_unit.sv
module subx_unit
  import subx_pkg::*;
#(
  parameter int DATA_BANKS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [15:0]         instr,
  input  logic                bank_load,
  input  logic [BANK_W-1:0]   bank_din,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [1:0]          phase,
  output logic [DATA_W-1:0]   w_out,
  output logic [4:0]          status_out,
  output logic [DATA_W-1:0]   rd_data
);
  localparam logic [1:0] PH_Q1 = 2'd0;
  localparam logic [1:0] PH_Q2 = 2'd1;
  localparam logic [1:0] PH_Q3 = 2'd2;
  localparam logic [1:0] PH_Q4 = 2'd3;

  logic [1:0]        phase_q;
  logic [15:0]       ir_q;
  logic [BANK_W-1:0] bsr_q;
  logic [DATA_W-1:0] w_q, opnd_q, res_q;
  logic [ADDR_W-1:0] addr_q;
  flags_t            st_q, flg_q;

  op_e               op;
  logic              dest_f, acc_sel;
  logic [DATA_W-1:0] field;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_rdata;

  // named events for the checks
  logic commit_ev, write_w_ev, write_f_ev;

  subx_decode u_dec (
    .ir(ir_q), .op(op), .dest_f(dest_f), .acc_sel(acc_sel), .field(field)
  );

  assign op_addr = eff_address(field, acc_sel, bsr_q);

  assign commit_ev  = (phase_q == PH_Q4);
  assign write_w_ev = commit_ev && ((op == OP_LIT) || (op == OP_REG && !dest_f));
  assign write_f_ev = commit_ev && (op == OP_REG) && dest_f;

  subx_regfile #(.DATA_BANKS(DATA_BANKS)) u_rf (
    .clk(clk), .rst(rst),
    .wr_en(write_f_ev), .wr_addr(addr_q), .wr_data(res_q),
    .rd0_addr(rd_addr), .rd0_data(rd_data),
    .rd1_addr(op_addr), .rd1_data(op_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_Q1;
      ir_q    <= '0;
      bsr_q   <= '0;
      w_q     <= '0;
      st_q    <= '0;
      opnd_q  <= '0;
      res_q   <= '0;
      flg_q   <= '0;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_q + 2'd1;
      if (bank_load) bsr_q <= bank_din;
      case (phase_q)
        PH_Q1: ir_q <= instr;
        PH_Q2: begin
          addr_q <= op_addr;
          opnd_q <= (op == OP_LIT) ? field : op_rdata;
        end
        PH_Q3: begin
          res_q <= sub_result(opnd_q, w_q);
          flg_q <= sub_flags(opnd_q, w_q);
        end
        default: begin
          if (op != OP_NONE) st_q <= flg_q;
          if (write_w_ev) w_q <= res_q;
        end
      endcase
    end
  end

  assign phase      = phase_q;
  assign w_out      = w_q;
  assign status_out = st_q;

  assert_phase_step_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase_q == $past(phase_q) + 2'd1);
  assert_w_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_Q4) |=> $stable(w_q));
  assert_status_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_Q4) |=> $stable(st_q));
  assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (commit_ev && op == OP_NONE) |=> $stable(w_q) && $stable(st_q));
  assert_zn_match_R8: assert property (@(posedge clk) disable iff (rst)
    write_w_ev |=> (st_q.z == (w_q == '0)) && (st_q.n == w_q[DATA_W-1]));
  assert_literal_diff_R1: assert property (@(posedge clk) disable iff (rst)
    (commit_ev && op == OP_LIT) |=> w_q == $past(ir_q[7:0]) - $past(w_q));
  assert_fdest_keeps_w_R2: assert property (@(posedge clk) disable iff (rst)
    write_f_ev |=> $stable(w_q));
endmodule

// File: tb/subx_unit_test.sv
module subx_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic        bank_load = 1'b0;
  logic [3:0]  bank_din = 4'h0;
  logic [11:0] rd_addr = 12'h000;
  logic [1:0]  phase;
  logic [7:0]  w_out;
  logic [4:0]  status_out;
  logic [7:0]  rd_data;

  localparam int NBANKS = 2;

  subx_unit #(.DATA_BANKS(NBANKS)) uut (
    .clk(clk), .rst(rst), .instr(instr), .bank_load(bank_load), .bank_din(bank_din),
    .rd_addr(rd_addr), .phase(phase), .w_out(w_out), .status_out(status_out),
    .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference state
  int m_w = 0;
  int m_bsr = 0;
  int m_st = 0;
  int m_mem [int];

  function automatic bit stored(int addr);
    int b = addr / 256;
    return (b == 15) || (b < NBANKS);
  endfunction

  function automatic int mread(int addr);
    if (!stored(addr)) return 0;
    if (m_mem.exists(addr)) return m_mem[addr];
    return 0;
  endfunction

  function automatic int ref_flags(int m, int w);
    int diff = m - w;
    int r = diff & 255;
    int sm = (m > 127) ? m - 256 : m;
    int sw = (w > 127) ? w - 256 : w;
    int sd = sm - sw;
    int c = (diff >= 0) ? 1 : 0;
    int dc = ((m % 16) >= (w % 16)) ? 1 : 0;
    int z = (r == 0) ? 1 : 0;
    int n = (r >= 128) ? 1 : 0;
    int ov = (sd > 127 || sd < -128) ? 1 : 0;
    return n * 16 + ov * 8 + z * 4 + dc * 2 + c;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Runs one instruction cycle starting at a phase-0 negedge
  task automatic exec(input logic [15:0] ins, input bit ld, input int bv, input string req);
    int old_w, old_st, m, res, addr, dst_is_f, is_sub;
    chk(phase == 2'd0, "R11", "phase at issue", phase, 0);
    instr = ins;
    bank_load = ld;
    bank_din = bv[3:0];
    if (ld) m_bsr = bv;
    old_w = m_w;
    old_st = m_st;
    is_sub = 0;
    dst_is_f = 0;
    addr = -1;
    if (ins[15:8] == 8'h08) begin
      is_sub = 1;
      m = ins[7:0];
    end else if (ins[15:10] == 6'b010111) begin
      is_sub = 1;
      if (ins[8]) addr = m_bsr * 256 + ins[7:0];
      else addr = (ins[7:0] >= 128) ? 15 * 256 + ins[7:0] : ins[7:0];
      m = mread(addr);
      dst_is_f = ins[9];
    end
    for (int p = 1; p < 4; p++) begin
      @(negedge clk);
      bank_load = 1'b0;
      chk(phase == p[1:0], "R11", "phase count", phase, p);
      chk(w_out == old_w[7:0], "R11", "W held before Q4", w_out, old_w);
      chk(status_out == old_st[4:0], "R11", "flags held before Q4", status_out, old_st);
    end
    @(negedge clk);
    if (is_sub) begin
      res = (m - m_w) & 255;
      m_st = ref_flags(m, m_w);
      if (dst_is_f) begin
        if (stored(addr)) m_mem[addr] = res;
      end else m_w = res;
    end
    chk(w_out == m_w[7:0], req, "W after commit", w_out, m_w);
    chk(status_out == m_st[4:0], req, "flags after commit", status_out, m_st);
    if (addr >= 0) begin
      rd_addr = addr[11:0];
      #1;
      chk(rd_data == mread(addr), req, "data byte after commit", rd_data, mread(addr));
    end
  endtask

  task automatic set_w(int v);
    exec({8'h08, 8'((v + m_w) & 255)}, 0, 0, "R1");
  endtask

  // writes v to byte f of bank b through a=1 write-back on a zero byte
  task automatic set_byte(int b, int f, int v);
    set_w((256 - v) & 255);
    exec({6'b010111, 1'b1, 1'b1, 8'(f)}, 1, b, "R2");
  endtask

  task automatic peek(int addr, int exp, string req);
    rd_addr = addr[11:0];
    #1;
    chk(rd_data == exp[7:0], req, "read port", rd_data, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_w = 0; m_bsr = 0; m_st = 0;
    m_mem.delete();
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R12: reset state
    chk(w_out == 8'h00, "R12", "W after reset", w_out, 0);
    chk(status_out == 5'h00, "R12", "flags after reset", status_out, 0);
    chk(phase == 2'd0, "R12", "phase after reset", phase, 0);
    peek(12'h010, 0, "R12");
    peek(12'hF85, 0, "R12");

    // R1, R6, R8: 2-0, 2-2, 2-3
    exec(16'h0802, 0, 0, "R1");
    exec(16'h0802, 0, 0, "R8");
    set_w(3);
    exec(16'h0802, 0, 0, "R6");
    // R7: nibble borrow without full borrow: 0x20 - 0x01
    set_w(1);
    exec(16'h0820, 0, 0, "R7");

    // R2 / R3 / R9: byte 0x10 in bank 0 = 0x80, W = 1
    set_byte(0, 8'h10, 8'h80);
    set_w(1);
    exec({6'b010111, 1'b0, 1'b0, 8'h10}, 0, 0, "R3"); // d=0 -> W=0x7F, OV
    set_w(1);
    exec({6'b010111, 1'b1, 1'b0, 8'h10}, 0, 0, "R2"); // d=1 -> byte 0x7F
    // R9: positive minus negative overflows
    set_w(8'h90);
    exec(16'h0870, 0, 0, "R9");

    // R4: access high half goes to bank 15 regardless of the bank register
    set_byte(15, 8'h85, 8'h33);
    set_w(3);
    exec({6'b010111, 1'b0, 1'b0, 8'h85}, 1, 1, "R4");
    exec({6'b010111, 1'b1, 1'b0, 8'h20}, 1, 1, "R4");
    peek(12'h020, 8'h00 - 8'h30 + 8'h00, "R4");
    peek(12'h120, 0, "R4");

    // R5: bank 1 banked access, unimplemented bank 5 drops writes
    set_byte(1, 8'h40, 8'h55);
    peek(12'h140, 8'h55, "R5");
    peek(12'h040, 0, "R5");
    set_w(8'h11);
    exec({6'b010111, 1'b1, 1'b1, 8'h40}, 1, 5, "R5");
    peek(12'h540, 0, "R5");

    // R10: other opcodes leave everything untouched
    exec(16'h0902, 0, 0, "R10");
    exec(16'h5B10, 0, 0, "R10");
    exec(16'hFFFF, 0, 0, "R10");
    exec(16'h0000, 0, 0, "R10");
    peek(12'h010, 8'h7F, "R10");

    // mixed random traffic against the reference model (R1..R10)
    for (int i = 0; i < 60; i++) begin
      int kind = $urandom_range(0, 3);
      int f = $urandom_range(0, 255);
      int b = $urandom_range(0, 15);
      if (kind == 0) exec({8'h08, 8'(f)}, 0, 0, "R1");
      else if (kind == 1) exec({6'b010111, 1'($urandom_range(0, 1)), 1'b0, 8'(f)}, 0, 0, "R4");
      else if (kind == 2) exec({6'b010111, 1'($urandom_range(0, 1)), 1'b1, 8'(f)}, 1, b, "R5");
      else exec(16'(($urandom_range(0, 65535) & 16'hF3FF) | 16'h0400), 0, 0, "R10");
    end

    // R12: reset mid-run clears everything
    set_byte(0, 8'h22, 8'h99);
    do_reset();
    chk(w_out == 8'h00, "R12", "W after second reset", w_out, 0);
    chk(status_out == 5'h00, "R12", "flags after second reset", status_out, 0);
    peek(12'h022, 0, "R12");
    // bank register cleared: a=1 access uses bank 0
    set_w(8'h01);
    exec({6'b010111, 1'b1, 1'b1, 8'h22}, 0, 0, "R12");
    peek(12'h022, 8'hFF, "R12");

    finish_run();
  end
endmodule